// File: doc/BRIEF.md
# Tick-Disciplined Mission Time Counter

The block keeps a mission clock made of a coarse seconds count and a fine sub-second count. The fine count advances once every prescaler period. When it wraps from all ones to zero, the coarse count steps by one. An external single-cycle tick marks a true second boundary and realigns the clock to it. The top bit of the coarse count is a desynchronisation flag. The counter sets this flag once ticks have been missing for a set number of seconds, and it keeps counting on its own while the flag is set.

Software reaches the block through an APB slave that never inserts wait states and never reports an error. A write to the load register stores a new coarse value. That value stays pending and is applied at the next tick, so the seconds count only jumps on a second boundary. A write with the soft-reset bit set clears the whole time base. Two read registers return the coarse count and the fine count. The coarse and fine values are also driven out on their own ports, and as one concatenated time word with the coarse value in the upper bits.

Top module: `mission_timer`

## Requirements
- R1: While reset is asserted, and directly after it, coarse and fine are zero. `time_o` always equals `{coarse_o, fine_o}`.
- R2: After a tick at clock edge E, the fine count holds 0 until edge E+PRESCALE_DIV. It then increments by one every PRESCALE_DIV edges.
- R3: When the fine count wraps from all ones to zero, coarse bits COARSE_W-2:0 increment by one. The flag bit (COARSE_W-1) keeps its value, unless R7 sets it at that same wrap.
- R4: At the clock edge that samples `tick_i` high, the fine count and the prescaler restart from zero. With no load pending, the flag is cleared. The coarse low bits increment if the fine count was nonzero, and stay unchanged if it was zero.
- R5: In any cycle where the coarse value differs from the previous cycle, the fine value is zero.
- R6: A write to byte offset 0x4 stores the written 32-bit value as pending. The coarse count does not change because of the write, and steps by at most one per cycle until the next tick. At that tick the coarse count takes the stored value exactly, including bit 31.
- R7: When DESYNC_SECONDS fine wraps have occurred since the last tick or reset, the flag is set at that wrap, together with the normal increment. It stays set until a tick or a soft reset.
- R8: A write to offset 0x0 with bit 1 set clears coarse, fine, the prescaler, the wrap count and any pending load at that edge. A write to offset 0x0 with bit 1 clear has no effect.
- R9: A read returns the coarse count at offset 0x8 and the fine count zero-extended at offset 0xC. Offsets 0x0 and 0x4 read as zero. `pready_o` is always 1 and `pslverr_o` is always 0.
- R10: The lower COARSE_W+FINE_W-1 bits of the time word never decrease from one cycle to the next, except at a tick edge or a soft-reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counter and the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle second-boundary pulse |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write, high for a write |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| coarse_o | output | COARSE_W | Coarse seconds; top bit is the desync flag |
| fine_o | output | FINE_W | Fine sub-second count |
| time_o | output | COARSE_W+FINE_W | Concatenated time word, coarse in the upper bits |

## Verification
The bench exercises ticks that arrive at fine zero and at fine nonzero. A design that always increments on a tick would double-count a second right after a wrap, and one that never increments would lose a second. A load is written and then observed across a wrap before any tick arrives. A design that applied the load at once would show the new seconds early, and one that dropped bit 31 would never let software raise the flag. A free-running stretch checks the flag at the wrap where it should be set and at a later wrap where it must persist. A soft reset with a load still pending is followed by a tick at fine zero. A design that kept the pending value would jump to that value instead of staying at zero.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   // Word-offset decode of the register window (byte offset >> 2)
   typedef enum logic [1:0] {
      MTC_CTRL   = 2'd0,
      MTC_LOAD   = 2'd1,
      MTC_COARSE = 2'd2,
      MTC_FINE   = 2'd3
   } mtc_reg_e;

   // Bit in the control word that requests a soft reset
   localparam int unsigned MTC_SRST_BIT = 1;

   // Commands raised by the bus slave towards the counter
   typedef struct packed {
      logic srst;
      logic load;
   } mtc_cmd_t;

endpackage

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
   parameter int unsigned DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic strobe
);

   generate
      if (DIV == 1) begin : g_bypass
         assign strobe = 1'b1;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(DIV);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (clr || cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign strobe = (cnt == LAST);

         AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST); // R2
         AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> cnt == '0); // R4
      end
   endgenerate

endmodule

// File: rtl/mtc_fine.sv
module mtc_fine #(
   parameter int unsigned FINE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [FINE_W-1:0] fine,
   output logic              wrap
);

   assign wrap = step && !clr && (fine == {FINE_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fine <= '0;
      else if (clr)
         fine <= '0;
      else if (step)
         fine <= fine + 1'b1;
   end

   AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !step |=> $stable(fine)); // R2
   AST_FINE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> fine == '0); // R3

endmodule

// File: rtl/mtc_coarse.sv
module mtc_coarse #(
   parameter int unsigned COARSE_W       = 32,
   parameter int unsigned DESYNC_SECONDS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                srst,
   input  logic                tick,
   input  logic                wrap,
   input  logic                fine_nz,
   input  logic                load_wr,
   input  logic [COARSE_W-1:0] load_val,
   output logic [COARSE_W-1:0] coarse
);

   localparam int unsigned QUIET_W = $clog2(DESYNC_SECONDS + 1);
   localparam logic [QUIET_W-1:0] QUIET_MAX = QUIET_W'(DESYNC_SECONDS);
   localparam int unsigned FLAG = COARSE_W - 1;

   logic                pending;
   logic [COARSE_W-1:0] pend_val;
   logic [QUIET_W-1:0]  quiet;
   logic [QUIET_W-1:0]  quiet_inc;
   logic [COARSE_W-2:0] low_inc;
   logic                goes_desync;

   assign quiet_inc   = (quiet == QUIET_MAX) ? quiet : quiet + 1'b1;
   assign goes_desync = (quiet_inc == QUIET_MAX);
   assign low_inc     = coarse[COARSE_W-2:0] + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse   <= '0;
         pending  <= 1'b0;
         pend_val <= '0;
         quiet    <= '0;
      end else if (srst) begin
         coarse   <= '0;
         pending  <= 1'b0;
         pend_val <= '0;
         quiet    <= '0;
      end else begin
         if (tick) begin
            quiet <= '0;
            if (pending)
               coarse <= pend_val;
            else
               coarse <= {1'b0, fine_nz ? low_inc : coarse[COARSE_W-2:0]};
         end else if (wrap) begin
            quiet  <= quiet_inc;
            coarse <= {coarse[FLAG] | goes_desync, low_inc};
         end
         if (load_wr) begin
            pending  <= 1'b1;
            pend_val <= load_val;
         end else if (tick) begin
            pending  <= 1'b0;
         end
      end
   end

   AST_COARSE_SMALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !srst |=> (coarse[COARSE_W-2:0] == $past(coarse[COARSE_W-2:0])) ||
                         (coarse[COARSE_W-2:0] == $past(coarse[COARSE_W-2:0]) + 1'b1)); // R6
   AST_LOAD_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !srst && pending |=> coarse == $past(pend_val)); // R6
   AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !srst && coarse[FLAG] |=> coarse[FLAG]); // R7
   AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coarse[FLAG]) |-> $past(wrap) || $past(tick)); // R7

endmodule

// File: rtl/mtc_apb.sv
module mtc_apb
   import mtc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned COARSE_W = 32,
   parameter int unsigned FINE_W   = 16
) (
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [DATA_W-1:0]   pwdata,
   input  logic [COARSE_W-1:0] coarse,
   input  logic [FINE_W-1:0]   fine,
   output mtc_cmd_t            cmd,
   output logic [COARSE_W-1:0] load_val,
   output logic [DATA_W-1:0]   prdata
);

   logic     upper_zero;
   logic     hit;
   logic     wr_acc;
   mtc_reg_e sel;

   generate
      if (ADDR_W > 4) begin : g_upper
         assign upper_zero = (paddr[ADDR_W-1:4] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign sel      = mtc_reg_e'(paddr[3:2]);
   assign hit      = upper_zero && (paddr[1:0] == 2'b00);
   assign wr_acc   = psel && penable && pwrite && hit;

   assign cmd.srst = wr_acc && (sel == MTC_CTRL) && pwdata[MTC_SRST_BIT];
   assign cmd.load = wr_acc && (sel == MTC_LOAD);
   assign load_val = pwdata[COARSE_W-1:0];

   always_comb begin
      prdata = '0;
      if (psel && !pwrite && hit) begin
         case (sel)
            MTC_COARSE: prdata[COARSE_W-1:0] = coarse;
            MTC_FINE:   prdata[FINE_W-1:0]   = fine;
            default:    prdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/mission_timer.sv
module mission_timer
   import mtc_pkg::*;
#(
   parameter int unsigned COARSE_W       = 32,
   parameter int unsigned FINE_W         = 16,
   parameter int unsigned PRESCALE_DIV   = 20,
   parameter int unsigned DESYNC_SECONDS = 4,
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned DATA_W         = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick_i,
   input  logic                       psel_i,
   input  logic                       penable_i,
   input  logic                       pwrite_i,
   input  logic [ADDR_W-1:0]          paddr_i,
   input  logic [DATA_W-1:0]          pwdata_i,
   output logic [DATA_W-1:0]          prdata_o,
   output logic                       pready_o,
   output logic                       pslverr_o,
   output logic [COARSE_W-1:0]        coarse_o,
   output logic [FINE_W-1:0]          fine_o,
   output logic [COARSE_W+FINE_W-1:0] time_o
);

   localparam int unsigned TIME_W = COARSE_W + FINE_W;

   generate
      if (PRESCALE_DIV < 1)   begin : g_bad_div   $error("PRESCALE_DIV must be at least 1"); end
      if (DESYNC_SECONDS < 1) begin : g_bad_des   $error("DESYNC_SECONDS must be at least 1"); end
      if (COARSE_W < 2 || COARSE_W > DATA_W) begin : g_bad_cw $error("COARSE_W must lie in 2..DATA_W"); end
      if (FINE_W < 2 || FINE_W > DATA_W)     begin : g_bad_fw $error("FINE_W must lie in 2..DATA_W"); end
      if (ADDR_W < 4)         begin : g_bad_aw    $error("ADDR_W must be at least 4"); end
   endgenerate

   mtc_cmd_t            cmd;
   logic [COARSE_W-1:0] load_val;
   logic                restart;
   logic                strobe;
   logic                wrap;

   assign restart = tick_i | cmd.srst;

   mtc_apb #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)
   ) u_apb (
      .psel(psel_i), .penable(penable_i), .pwrite(pwrite_i), .paddr(paddr_i),
      .pwdata(pwdata_i), .coarse(coarse_o), .fine(fine_o), .cmd(cmd),
      .load_val(load_val), .prdata(prdata_o)
   );

   mtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(restart), .strobe(strobe)
   );

   mtc_fine #(.FINE_W(FINE_W)) u_fine (
      .clk(clk), .rst_n(rst_n), .clr(restart), .step(strobe),
      .fine(fine_o), .wrap(wrap)
   );

   mtc_coarse #(.COARSE_W(COARSE_W), .DESYNC_SECONDS(DESYNC_SECONDS)) u_coarse (
      .clk(clk), .rst_n(rst_n), .srst(cmd.srst), .tick(tick_i), .wrap(wrap),
      .fine_nz(|fine_o), .load_wr(cmd.load), .load_val(load_val), .coarse(coarse_o)
   );

   assign time_o    = {coarse_o, fine_o};
   assign pready_o  = 1'b1;
   assign pslverr_o = 1'b0;

   AST_TICK_ZEROES_FINE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> fine_o == '0); // R4
   AST_COARSE_STEP_AT_FINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      coarse_o != $past(coarse_o) |-> fine_o == '0); // R5
   AST_TIME_NO_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_i) && !$past(cmd.srst) |->
         time_o[TIME_W-2:0] >= $past(time_o[TIME_W-2:0])); // R10
   AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.srst |=> coarse_o == '0 && fine_o == '0); // R8

endmodule

// File: tb/tb_mission_timer.sv
`timescale 1ns/1ps
module tb_mission_timer;

   localparam int unsigned CW  = 32;
   localparam int unsigned FW  = 4;
   localparam int unsigned DIV = 3;
   localparam int unsigned DES = 4;
   localparam int unsigned AW  = 12;
   localparam int unsigned DW  = 32;
   localparam int unsigned TW  = CW + FW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic          psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
   logic [AW-1:0] paddr_i = '0;
   logic [DW-1:0] pwdata_i = '0;
   logic [DW-1:0] prdata_o;
   logic          pready_o, pslverr_o;
   logic [CW-1:0] coarse_o;
   logic [FW-1:0] fine_o;
   logic [TW-1:0] time_o;

   mission_timer #(
      .COARSE_W(CW), .FINE_W(FW), .PRESCALE_DIV(DIV), .DESYNC_SECONDS(DES),
      .ADDR_W(AW), .DATA_W(DW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .psel_i(psel_i), .penable_i(penable_i),
      .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
      .pready_o(pready_o), .pslverr_o(pslverr_o), .coarse_o(coarse_o), .fine_o(fine_o),
      .time_o(time_o)
   );

   always #10 clk = ~clk;

   typedef struct {
      int            due;
      logic [CW-1:0] c;
      logic [FW-1:0] f;
      string         tag;
   } exp_t;

   exp_t   sb_q[$];
   int     cyc = 0;
   int     n_tests = 0;
   int     n_fail = 0;
   bit     started = 1'b0;
   bit     finished = 1'b0;
   bit     exempt[int];
   logic [CW-1:0] prev_c = '0;
   logic [TW-1:0] prev_t = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input int due, input logic [CW-1:0] c, input logic [FW-1:0] f,
                       input string tag);
      exp_t e;
      e.due = due; e.c = c; e.f = f; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: samples 5 ns after each rising edge
   always begin
      @(posedge clk);
      #5;
      cyc++;
      if (started && rst_n) begin
         for (int i = 0; i < sb_q.size(); ) begin
            if (sb_q[i].due == cyc) begin
               chk({sb_q[i].tag, " coarse"}, 64'(coarse_o), 64'(sb_q[i].c));
               chk({sb_q[i].tag, " fine"}, 64'(fine_o), 64'(sb_q[i].f));
               chk("R1 time word concat", 64'(time_o), 64'({coarse_o, fine_o}));
               sb_q.delete(i);
            end else if (sb_q[i].due < cyc) begin
               chk({sb_q[i].tag, " missed"}, 64'(sb_q[i].due), 64'(cyc));
               sb_q.delete(i);
            end else begin
               i++;
            end
         end
         if (coarse_o != prev_c)
            chk("R5 fine zero on coarse change", 64'(fine_o), 64'd0);
         if (!exempt.exists(cyc))
            chk("R10 no backstep", 64'(time_o[TW-2:0] >= prev_t[TW-2:0]), 64'd1);
      end
      prev_c = coarse_o;
      prev_t = time_o;
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic tick_now(output int edge_no);
      tick_i = 1'b1;
      edge_no = cyc + 1;
      exempt[edge_no] = 1'b1;
      step(1);
      tick_i = 1'b0;
   endtask

   task automatic apb_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int edge_no);
      psel_i = 1'b1; penable_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d;
      edge_no = cyc + 1;
      step(1);
      psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0; paddr_i = '0; pwdata_i = '0;
   endtask

   task automatic apb_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      psel_i = 1'b1; penable_i = 1'b1; pwrite_i = 1'b0; paddr_i = a;
      #1;
      chk(tag, 64'(prdata_o), 64'(exp));
      chk("R9 pready high", 64'(pready_o), 64'd1);
      chk("R9 pslverr low", 64'(pslverr_o), 64'd0);
      step(1);
      psel_i = 1'b0; penable_i = 1'b0; paddr_i = '0;
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int e1, e2, e3, e4, e5, s, w;
      step(3);
      chk("R1 coarse in reset", 64'(coarse_o), 64'd0);
      chk("R1 fine in reset", 64'(fine_o), 64'd0);
      rst_n = 1'b1;
      exempt[cyc + 1] = 1'b1;
      started = 1'b1;
      chk("R1 time after reset", 64'(time_o), 64'd0);
      apb_read(12'h008, 32'h0, "R9 coarse read after reset");

      // Tick while fine is zero: coarse must not advance
      e1 = cyc + 1;
      push(e1, 0, 0, "R4 tick at fine zero");
      push(e1 + 2, 0, 0, "R2 fine before first step");
      push(e1 + 3, 0, 1, "R2 fine first step");
      push(e1 + 5, 0, 1, "R2 fine held");
      push(e1 + 6, 0, 2, "R2 fine second step");
      push(e1 + 47, 0, 15, "R3 fine at all ones");
      push(e1 + 48, 1, 0, "R3 rollover steps coarse");
      push(e1 + 101, 2, 1, "R6 load not applied at write");
      push(e1 + 144, 3, 0, "R6 load still pending across wrap");
      push(e1 + 191, 3, 15, "R7 flag clear before limit");
      push(e1 + 192, 32'h8000_0004, 0, "R7 flag set at limit wrap");
      push(e1 + 240, 32'h8000_0005, 0, "R3 wrap keeps flag");
      tick_now(e1);

      wait_until(e1 + 10);
      apb_read(12'h00C, 32'h3, "R9 fine read");
      wait_until(e1 + 100);
      apb_write(12'h004, 32'h0000_1234, w);
      wait_until(e1 + 120);
      apb_read(12'h008, 32'h2, "R6 coarse read with load pending");

      // Tick applies the pending load
      wait_until(e1 + 250);
      push(e1 + 251, 32'h0000_1234, 0, "R6 load applied at tick");
      tick_now(e2);

      wait_until(e2 + 5);
      push(e2 + 7, 32'h0000_1234, 2, "R6 second load deferred");
      apb_write(12'h004, 32'h8000_5678, w);
      wait_until(e2 + 20);
      push(e2 + 21, 32'h8000_5678, 0, "R6 load keeps bit 31");
      tick_now(e3);

      // Resync: flag clears, seconds advance since fine was nonzero
      wait_until(e3 + 10);
      push(e3 + 11, 32'h0000_5679, 0, "R4 resync clears flag");
      tick_now(e4);
      wait_until(e4 + 30);
      push(e4 + 31, 32'h0000_567A, 0, "R4 tick at fine nonzero");
      tick_now(e5);

      // Soft reset with a load pending
      wait_until(e5 + 4);
      apb_write(12'h004, 32'hDEAD_0000, w);
      wait_until(e5 + 6);
      push(e5 + 7, 32'h0000_567A, 2, "R8 control write without bit 1");
      apb_write(12'h000, 32'h0000_0001, w);
      wait_until(e5 + 10);
      push(e5 + 11, 0, 0, "R8 soft reset clears");
      exempt[e5 + 11] = 1'b1;
      apb_write(12'h000, 32'h0000_0002, s);
      push(s + 1, 0, 0, "R8 pending load discarded");
      push(s + 4, 0, 1, "R8 counting restarts");
      tick_now(w);
      apb_read(12'h000, 32'h0, "R9 control reads zero");
      apb_read(12'h004, 32'h0, "R9 load reads zero");

      wait_until(s + 12);
      chk("R1 all expectations consumed", 64'(sb_q.size()), 64'd0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule